// File: doc/BRIEF.md
# Timekeeper with Alarm and Hourly Chime

This block keeps the time of day in BCD (hours, minutes, seconds) from a single fast reference clock, and drives one tone output that a buzzer or lamp can follow. Every counter runs in the reference clock domain. A divider turns the reference into single-cycle tick enables at 1 Hz and 5 Hz, and into two square-wave tones at 1 kHz and 500 Hz. All user switches pass through two-flop synchronisers before any logic uses them.

The user can step the minutes or the hours by hand. The step rate is selectable at 1 Hz or 5 Hz. A separate alarm time (hour and minute) is set the same way. A view switch puts the alarm setting on the display in place of the running time. During the whole minute that matches the alarm, the tone output carries the alarm tone, unless the alarm is disabled. Near the end of every hour a short chime pattern plays on the same output.

Top module: `digital_clock`

## Requirements
- R1: The divider produces a seconds tick once per CLK_HZ reference cycles, an adjust tick at five times that rate, and tones whose periods are CLK_HZ/1000 cycles (1 kHz) and CLK_HZ/500 cycles (500 Hz).
- R2: While `rst_n` is low at a clock edge (synchronous, active low), the time and the alarm setting clear to 00:00:00 and 00:00, and `tone_o` is low.
- R3: Seconds and minutes count in BCD from 00 to 59, and hours count from 00 to 23. The minutes step when a seconds tick arrives at second 59. The hours step when a seconds tick arrives at minute 59, second 59. So 23:59:59 rolls over to 00:00:00. A field holding a value that is not valid BCD, or is above its limit, returns to 00 on its next step.
- R4: While `adj_min_i` is high, the minutes step once on every adjust tick, and the carry from the seconds into the minutes is ignored.
- R5: While `adj_hr_i` is high, the hours step once on every adjust tick, and the carry from the minutes into the hours is ignored.
- R6: The adjust tick is the 1 Hz tick when `fast_adj_i` is low and the 5 Hz tick when it is high. This tick is used for both time adjustment and alarm setting.
- R7: The alarm hour (00 to 23) and the alarm minute (00 to 59) step on each adjust tick while `set_alarm_hr_i` or `set_alarm_min_i` is high, respectively. While `alarm_view_i` is high, the display shows the alarm hour and minute with seconds 00. Otherwise it shows the running time.
- R8: When `alarm_on_i` is high and the current hour and minute equal the alarm setting, the alarm carries the 500 Hz tone during odd seconds and the 1 kHz tone during even seconds. At any other time the alarm is low.
- R9: When `alarm_on_i` is low, the alarm contributes nothing to the output.
- R10: In minute 59, the chime carries the 500 Hz tone at seconds 51, 53, 55 and 57, and the 1 kHz tone at second 59. At all other times the chime is low.
- R11: `tone_o` is the registered OR of the chime and the alarm. The display outputs are also registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| adj_min_i | input | 1 | Hold high to step the minutes by hand |
| adj_hr_i | input | 1 | Hold high to step the hours by hand |
| fast_adj_i | input | 1 | Adjust rate: 0 gives 1 Hz, 1 gives 5 Hz |
| alarm_view_i | input | 1 | Show the alarm setting on the display |
| set_alarm_min_i | input | 1 | Hold high to step the alarm minute |
| set_alarm_hr_i | input | 1 | Hold high to step the alarm hour |
| alarm_on_i | input | 1 | Alarm enable; low silences the alarm |
| hours_o | output | 8 | Displayed hours, two BCD digits |
| minutes_o | output | 8 | Displayed minutes, two BCD digits |
| seconds_o | output | 8 | Displayed seconds, two BCD digits |
| tone_o | output | 1 | Combined chime and alarm tone |

## Verification
A wrong count in the divider shows up as a wrong spacing between changes on `seconds_o`, or between hand-adjusted steps. Measuring one interval is enough to expose it. A missed or doubled carry shows at the ports on the next seconds tick as a wrong digit pair. A broken rollover shows at 23:59:59, and this project drives the time there quickly by hand. Errors in the tone mux appear within one second: the wrong tone frequency, or any edge on `tone_o` where silence is expected. The bench classifies the tone by counting its edges in a window placed in the middle of each second.

// File: rtl/clk_pkg.sv
package clk_pkg;
  typedef logic [7:0] bcd2_t;

  // tone half-periods of 1 kHz that make up one second / one adjust tick
  localparam int HALVES_PER_5HZ = 400;
  localparam int TICK5_PER_SEC  = 5;

  function automatic logic bcd2_le(input bcd2_t v, input int limit);
    return (v[3:0] <= 4'd9) && (int'(v[7:4]) * 10 + int'(v[3:0]) <= limit);
  endfunction
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import clk_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick1,
  output logic tick5,
  output logic tone1k,
  output logic tone500
);
  localparam int HALF1K = CLK_HZ / 2000;
  localparam int PW     = $clog2(HALF1K) + 1;
  localparam int C5W    = $clog2(HALVES_PER_5HZ);
  localparam int C1W    = $clog2(TICK5_PER_SEC);

  logic [PW-1:0]  pre_q;
  logic [C5W-1:0] c5_q;
  logic [C1W-1:0] c1_q;
  logic           half_pulse;
  logic           wrap5;

  assign half_pulse = (pre_q == PW'(HALF1K - 1));
  assign wrap5      = half_pulse && (c5_q == C5W'(HALVES_PER_5HZ - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      c5_q    <= '0;
      c1_q    <= '0;
      tick1   <= 1'b0;
      tick5   <= 1'b0;
      tone1k  <= 1'b0;
      tone500 <= 1'b0;
    end else begin
      pre_q <= half_pulse ? '0 : pre_q + 1'b1;
      tick5 <= wrap5;
      tick1 <= wrap5 && (c1_q == C1W'(TICK5_PER_SEC - 1));
      if (half_pulse) begin
        c5_q   <= wrap5 ? '0 : c5_q + 1'b1;
        tone1k <= ~tone1k;
        if (tone1k) tone500 <= ~tone500;
      end
      if (wrap5) c1_q <= (c1_q == C1W'(TICK5_PER_SEC - 1)) ? '0 : c1_q + 1'b1;
    end
  end

  assert_tick_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick1 |-> tick5);
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick5 |=> !tick5);
endmodule

// File: rtl/bcd_wheel.sv
module bcd_wheel
  import clk_pkg::*;
#(
  parameter int LIMIT = 59
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  output bcd2_t val
);
  localparam logic [3:0] LT = 4'(LIMIT / 10);
  localparam logic [3:0] LO = 4'(LIMIT % 10);

  bcd2_t nxt;

  always_comb begin
    if (val[3:0] > 4'd9 || val[7:4] > LT || (val[7:4] == LT && val[3:0] >= LO))
      nxt = '0;
    else if (val[3:0] == 4'd9)
      nxt = {val[7:4] + 4'd1, 4'd0};
    else
      nxt = {val[7:4], val[3:0] + 4'd1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    val <= '0;
    else if (step) val <= nxt;
  end

  assert_bcd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bcd2_le(val, LIMIT));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(val));
endmodule

// File: rtl/digital_clock.sv
module digital_clock
  import clk_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adj_min_i,
  input  logic       adj_hr_i,
  input  logic       fast_adj_i,
  input  logic       alarm_view_i,
  input  logic       set_alarm_min_i,
  input  logic       set_alarm_hr_i,
  input  logic       alarm_on_i,
  output logic [7:0] hours_o,
  output logic [7:0] minutes_o,
  output logic [7:0] seconds_o,
  output logic       tone_o
);
  localparam int NSW = 7;

  logic [NSW-1:0] sw_raw, sw_s;
  logic adj_min_s, adj_hr_s, fast_s, view_s, set_min_s, set_hr_s, alarm_on_s;
  logic tick1, tick5, tone1k, tone500, adj_tick;
  logic step_min, step_hr;
  bcd2_t sec_q, min_q, hr_q, amin_q, ahr_q;
  logic alarm_sig, chime_sig;

  assign sw_raw = {alarm_on_i, set_alarm_hr_i, set_alarm_min_i, alarm_view_i,
                   fast_adj_i, adj_hr_i, adj_min_i};

  sync2 #(.W(NSW)) u_sync (.clk(clk), .rst_n(rst_n), .d(sw_raw), .q(sw_s));

  assign {alarm_on_s, set_hr_s, set_min_s, view_s, fast_s, adj_hr_s, adj_min_s} = sw_s;

  tick_divider #(.CLK_HZ(CLK_HZ)) u_div (
    .clk(clk), .rst_n(rst_n), .tick1(tick1), .tick5(tick5),
    .tone1k(tone1k), .tone500(tone500));

  assign adj_tick = fast_s ? tick5 : tick1;
  assign step_min = adj_min_s ? adj_tick : (tick1 && sec_q == 8'h59);
  assign step_hr  = adj_hr_s  ? adj_tick : (tick1 && sec_q == 8'h59 && min_q == 8'h59);

  bcd_wheel #(.LIMIT(59)) u_sec  (.clk(clk), .rst_n(rst_n), .step(tick1),    .val(sec_q));
  bcd_wheel #(.LIMIT(59)) u_min  (.clk(clk), .rst_n(rst_n), .step(step_min), .val(min_q));
  bcd_wheel #(.LIMIT(23)) u_hr   (.clk(clk), .rst_n(rst_n), .step(step_hr),  .val(hr_q));
  bcd_wheel #(.LIMIT(59)) u_amin (.clk(clk), .rst_n(rst_n),
                                  .step(set_min_s && adj_tick), .val(amin_q));
  bcd_wheel #(.LIMIT(23)) u_ahr  (.clk(clk), .rst_n(rst_n),
                                  .step(set_hr_s && adj_tick), .val(ahr_q));

  always_comb begin
    alarm_sig = alarm_on_s && (hr_q == ahr_q) && (min_q == amin_q) &&
                (sec_q[0] ? tone500 : tone1k);
    chime_sig = 1'b0;
    if (min_q == 8'h59) begin
      case (sec_q)
        8'h51, 8'h53, 8'h55, 8'h57: chime_sig = tone500;
        8'h59:                      chime_sig = tone1k;
        default:                    chime_sig = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hours_o   <= '0;
      minutes_o <= '0;
      seconds_o <= '0;
      tone_o    <= 1'b0;
    end else begin
      hours_o   <= view_s ? ahr_q  : hr_q;
      minutes_o <= view_s ? amin_q : min_q;
      seconds_o <= view_s ? 8'h00  : sec_q;
      tone_o    <= alarm_sig | chime_sig;
    end
  end

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick1 && sec_q == 8'h59) |=> (sec_q == 8'h00));
  assert_min_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_min_s && !(tick1 && sec_q == 8'h59)) |=> $stable(min_q));
  assert_hr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_hr_s && !(tick1 && sec_q == 8'h59 && min_q == 8'h59)) |=> $stable(hr_q));
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_on_s && min_q != 8'h59) |=> !tone_o);
endmodule

// File: tb/tb_digital_clock.sv
module tb_digital_clock;
  localparam int CLK_HZ = 2000;   // seconds tick every 2000 cycles, 1 kHz tone toggles each cycle
  localparam int WIN    = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adj_min = 0, adj_hr = 0, fast = 0, view = 0, set_min = 0, set_hr = 0, alarm_on = 0;
  logic [7:0] hours, minutes, seconds;
  logic tone;
  int total = 0, bad = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  digital_clock #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .adj_min_i(adj_min), .adj_hr_i(adj_hr),
    .fast_adj_i(fast), .alarm_view_i(view), .set_alarm_min_i(set_min),
    .set_alarm_hr_i(set_hr), .alarm_on_i(alarm_on),
    .hours_o(hours), .minutes_o(minutes), .seconds_o(seconds), .tone_o(tone));

  // chime vectors for minute 59: {seconds BCD, class} class 0 none, 1 500 Hz, 2 1 kHz
  localparam logic [9:0] CHIME_TAB [0:9] = '{
    {8'h50, 2'd0}, {8'h51, 2'd1}, {8'h52, 2'd0}, {8'h53, 2'd1}, {8'h54, 2'd0},
    {8'h55, 2'd1}, {8'h56, 2'd0}, {8'h57, 2'd1}, {8'h58, 2'd0}, {8'h59, 2'd2}};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_sec(input logic [7:0] v);
    @(negedge clk);
    while (seconds !== v) @(negedge clk);
  endtask

  task automatic measure(output int cls);
    int edges = 0;
    logic prev;
    @(negedge clk);
    prev = tone;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (tone !== prev) edges++;
      prev = tone;
    end
    cls = (edges > 150) ? 2 : (edges >= 50 && edges <= 150) ? 1 : (edges == 0) ? 0 : 3;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cls;
    longint t0, t_last, t_mn;
    logic [7:0] prev_mn, prev_hr;
    bit iv_done;

    // R2 reset state
    repeat (5) @(negedge clk);
    check(hours == 8'h00 && minutes == 8'h00 && seconds == 8'h00, "R2", "time after reset",
          {hours, minutes, seconds}, 0);
    check(tone == 1'b0, "R2", "tone in reset", tone, 0);
    rst_n = 1'b1;

    // R1 seconds spacing
    wait_sec(8'h01); t0 = cyc;
    wait_sec(8'h02);
    check(cyc - t0 == CLK_HZ, "R1", "seconds interval", cyc - t0, CLK_HZ);

    // R4 R5 R6 hand adjust at 5 Hz up to 23:59
    fast = 1; adj_hr = 1; adj_min = 1;
    prev_mn = minutes; prev_hr = hours; t_mn = 0; iv_done = 0;
    while (!(hours == 8'h23 && minutes == 8'h59)) begin
      @(negedge clk);
      if (minutes != prev_mn) begin
        if (t_mn != 0 && !iv_done) begin
          check(cyc - t_mn == CLK_HZ / 5, "R6", "5 Hz adjust interval", cyc - t_mn, CLK_HZ / 5);
          iv_done = 1;
        end
        t_mn = cyc;
        prev_mn = minutes;
      end
      if (hours == 8'h23) adj_hr = 0;
      if (minutes == 8'h59) adj_min = 0;
    end
    check(hours == 8'h23, "R5", "hours after adjust", hours, 8'h23);
    check(minutes == 8'h59, "R4", "minutes after adjust", minutes, 8'h59);
    repeat (CLK_HZ) @(negedge clk);
    check(hours == 8'h23 && minutes == 8'h59, "R4", "fields hold after release",
          {hours, minutes}, 16'h2359);

    // R10 R11 chime pattern table
    for (int k = 0; k < 10; k++) begin
      wait_sec(CHIME_TAB[k][9:2]);
      repeat (100) @(negedge clk);
      measure(cls);
      check(cls == int'(CHIME_TAB[k][1:0]), "R10", "chime class", cls, CHIME_TAB[k][1:0]);
    end

    // R3 rollover
    wait_sec(8'h00);
    check(hours == 8'h00 && minutes == 8'h00, "R3", "rollover 23:59:59", {hours, minutes}, 0);

    // R8 alarm at 00:00 (reset value)
    alarm_on = 1;
    wait_sec(8'h01); repeat (100) @(negedge clk); measure(cls);
    check(cls == 1, "R8", "alarm odd second 500 Hz", cls, 1);
    wait_sec(8'h02); repeat (100) @(negedge clk); measure(cls);
    check(cls == 2, "R8", "alarm even second 1 kHz", cls, 2);
    alarm_on = 0;
    wait_sec(8'h03); repeat (100) @(negedge clk); measure(cls);
    check(cls == 0, "R9", "alarm silenced", cls, 0);

    // R7 alarm view and setting
    view = 1; repeat (10) @(negedge clk);
    check(hours == 8'h00 && minutes == 8'h00 && seconds == 8'h00, "R7", "alarm view reset value",
          {hours, minutes, seconds}, 0);
    fast = 0; set_min = 1;
    prev_mn = minutes;
    while (minutes == prev_mn) @(negedge clk);
    t_last = cyc; prev_mn = minutes;
    while (minutes == prev_mn) @(negedge clk);
    set_min = 0;
    check(cyc - t_last == CLK_HZ, "R6", "1 Hz adjust interval", cyc - t_last, CLK_HZ);
    fast = 1; set_hr = 1;
    while (hours != 8'h01) @(negedge clk);
    set_hr = 0;
    repeat (CLK_HZ / 2) @(negedge clk);
    check(hours == 8'h01 && minutes == 8'h02 && seconds == 8'h00, "R7", "alarm set 01:02",
          {hours, minutes, seconds}, 24'h010200);
    view = 0; repeat (10) @(negedge clk);
    check(hours == 8'h00 && minutes == 8'h00, "R7", "running time shown again",
          {hours, minutes}, 0);

    // R8 no match, no tone
    alarm_on = 1;
    prev_hr = seconds;
    while (seconds == prev_hr) @(negedge clk);
    repeat (100) @(negedge clk); measure(cls);
    check(cls == 0, "R8", "alarm mismatch quiet", cls, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule